// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This core executes a single kind of instruction: a bundle of data transports. Each instruction word holds a fixed number of move slots, one for each transport bus. Every slot names where a value comes from and where it goes. No opcode exists. Arithmetic happens only because a value is written into one of the ALU's trigger ports. That write combines the value with whatever sits in the operand latch, and the outcome lands in a result register. That register can then be moved back into the general registers.

All slots of an accepted instruction read their sources as they stood at the start of the cycle. All of their writes commit together at the clock edge. Instructions arrive over a valid/ready interface, and the core accepts one every cycle. An external data input serves as a source endpoint, so constants can be brought in. A debug read port exposes any general register. The operand latch, the result register and a sticky error flag are brought out as well.

Top module: `tta_core`

## Requirements
- R1: Reset clears every general register, the operand latch, the result register and the error flag; `instr_ready` is high whenever reset is released.
- R2: A slot is 11 bits: bit 10 valid, bits 9:5 source code, bits 4:0 destination code; slot k occupies instruction bits [11k+10:11k]. Codes 0–7 name registers; a register-to-register move copies the value, and every slot reads the values from before the instruction, so two slots can swap two registers.
- R3: Writing destination code 8 (operand port) only latches the value; the result register does not change.
- R4: Writing destination codes 9, 10, 11, 12, 13 sets the result to operand+value, operand−value, operand AND value, operand OR value, operand XOR value (16-bit, wrapping). The result shows on the clock edge that ends the triggering instruction and holds until the next trigger. A trigger uses the operand latch value from before its instruction.
- R5: Source code 14 reads the result register; in the same instruction as a trigger write it returns the previous result.
- R6: When two slots of one instruction write the same destination, the higher-numbered slot's value is kept.
- R7: A valid slot whose source code is 8–13 or 16–31, or whose destination code is 14–31, changes nothing and sets `err_flag`, which stays set until reset. Other slots in the same instruction still take effect.
- R8: Source code 15 reads `ext_in`. A slot whose valid bit is 0, or any word presented while `instr_valid` is low, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Core can take an instruction (always high out of reset) |
| instr_word | input | 22 | Two move slots |
| ext_in | input | 16 | External data source (code 15) |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Contents of the selected register |
| operand_val | output | 16 | Operand latch |
| result_val | output | 16 | ALU result register |
| err_flag | output | 1 | Sticky illegal-move flag |

## Verification
The bench swaps two registers with one instruction. A design that read the first slot's write in the second slot would end with both registers equal. It puts a result read beside a trigger, and an operand write beside a trigger. A core with a forwarding path would return the new result, or compute with the new operand, instead of the old values. It sends two slots to one destination to catch a reversed priority order. It sends illegal codes in one slot and a legal move in the other, to catch a core that drops the whole instruction, writes a wrapped register index, or lets the error flag clear.

// File: rtl/tta_pkg.sv
package tta_pkg;
  // Endpoint codes are placed after the register block.
  localparam int OFS_OPND = 0;  // operand port  = NREG + 0
  localparam int OFS_TRIG = 1;  // first trigger = NREG + 1
  localparam int NUM_TRIG = 5;
  localparam int OFS_RES  = 6;  // result port   = NREG + 6
  localparam int OFS_EXT  = 7;  // external in   = NREG + 7

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;
endpackage

// File: rtl/tta_slot_dec.sv
module tta_slot_dec
  import tta_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int CODE_W = 5,
  localparam int IDX_W  = $clog2(NREG),
  localparam int SLOT_W = 2 * CODE_W + 1
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic              act_o,
  output logic              bad_o,
  output logic              src_res_o,
  output logic              src_ext_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic              dst_reg_o,
  output logic              dst_opnd_o,
  output logic              dst_trig_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output alu_op_e           trig_op_o
);
  logic              vld;
  logic [CODE_W-1:0] src, dst;
  logic              src_reg, src_ok, dst_ok;

  assign vld = slot_i[2*CODE_W];
  assign src = slot_i[2*CODE_W-1:CODE_W];
  assign dst = slot_i[CODE_W-1:0];

  assign src_reg   = src < CODE_W'(NREG);
  assign src_res_o = src == CODE_W'(NREG + OFS_RES);
  assign src_ext_o = src == CODE_W'(NREG + OFS_EXT);
  assign src_ok    = src_reg | src_res_o | src_ext_o;

  assign dst_reg_o  = dst < CODE_W'(NREG);
  assign dst_opnd_o = dst == CODE_W'(NREG + OFS_OPND);
  assign dst_trig_o = (dst >= CODE_W'(NREG + OFS_TRIG)) &&
                      (dst <  CODE_W'(NREG + OFS_TRIG + NUM_TRIG));
  assign dst_ok     = dst_reg_o | dst_opnd_o | dst_trig_o;

  assign act_o = vld & src_ok & dst_ok;
  assign bad_o = vld & ~(src_ok & dst_ok);

  assign src_idx_o = src[IDX_W-1:0];
  assign dst_idx_o = dst[IDX_W-1:0];

  always_comb begin
    if (dst == CODE_W'(NREG + OFS_TRIG + 1))      trig_op_o = OP_SUB;
    else if (dst == CODE_W'(NREG + OFS_TRIG + 2)) trig_op_o = OP_AND;
    else if (dst == CODE_W'(NREG + OFS_TRIG + 3)) trig_op_o = OP_OR;
    else if (dst == CODE_W'(NREG + OFS_TRIG + 4)) trig_op_o = OP_XOR;
    else                                          trig_op_o = OP_ADD;
  end
endmodule

// File: rtl/tta_regfile.sv
module tta_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int NSLOT  = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSLOT-1:0]              we_i,
  input  logic [NSLOT-1:0][IDX_W-1:0]   widx_i,
  input  logic [NSLOT-1:0][DATA_W-1:0]  wdat_i,
  output logic [NREG-1:0][DATA_W-1:0]   rd_all_o
);
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  // Ascending slot order: the last matching write wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (we_i[s]) regs_q[widx_i[s]] <= wdat_i[s];
      end
    end
  end

  assign rd_all_o = regs_q;
endmodule

// File: rtl/tta_alu_unit.sv
module tta_alu_unit
  import tta_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opnd_we_i,
  input  logic [DATA_W-1:0] opnd_d_i,
  input  logic              fire_i,
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] opnd_q_o,
  output logic [DATA_W-1:0] result_q_o
);
  function automatic logic [DATA_W-1:0] alu_eval(alu_op_e op,
                                                 logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_q_o   <= '0;
      result_q_o <= '0;
    end else begin
      if (opnd_we_i) opnd_q_o <= opnd_d_i;
      if (fire_i)    result_q_o <= alu_eval(op_i, opnd_q_o, val_i);
    end
  end
endmodule

// File: rtl/tta_core.sv
module tta_core
  import tta_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int NSLOT  = 2,
  parameter int CODE_W = 5,
  localparam int IDX_W  = $clog2(NREG),
  localparam int SLOT_W = 2 * CODE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    instr_valid,
  output logic                    instr_ready,
  input  logic [NSLOT*SLOT_W-1:0] instr_word,
  input  logic [DATA_W-1:0]       ext_in,
  input  logic [IDX_W-1:0]        dbg_sel,
  output logic [DATA_W-1:0]       dbg_data,
  output logic [DATA_W-1:0]       operand_val,
  output logic [DATA_W-1:0]       result_val,
  output logic                    err_flag
);
  logic                         accept;
  logic [NSLOT-1:0]             act, bad, src_res, src_ext;
  logic [NSLOT-1:0]             dst_reg, dst_opnd, dst_trig;
  logic [NSLOT-1:0][IDX_W-1:0]  src_idx, dst_idx;
  alu_op_e                      trig_op [NSLOT];
  logic [NSLOT-1:0][DATA_W-1:0] slot_dat;
  logic [NREG-1:0][DATA_W-1:0]  reg_rd;
  logic [NSLOT-1:0]             reg_we;

  // Named events for the checker
  logic                         trig_fire;
  logic                         opnd_we;
  logic                         any_bad;
  alu_op_e                      fire_op;
  logic [DATA_W-1:0]            fire_val, opnd_d, result_q, opnd_q;
  logic                         err_q;

  assign instr_ready = 1'b1;
  assign accept      = instr_valid & instr_ready;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    tta_slot_dec #(.NREG(NREG), .CODE_W(CODE_W)) u_dec (
      .slot_i    (instr_word[s*SLOT_W +: SLOT_W]),
      .act_o     (act[s]),
      .bad_o     (bad[s]),
      .src_res_o (src_res[s]),
      .src_ext_o (src_ext[s]),
      .src_idx_o (src_idx[s]),
      .dst_reg_o (dst_reg[s]),
      .dst_opnd_o(dst_opnd[s]),
      .dst_trig_o(dst_trig[s]),
      .dst_idx_o (dst_idx[s]),
      .trig_op_o (trig_op[s])
    );
    // Sources are read from state held before this instruction.
    assign slot_dat[s] = src_ext[s] ? ext_in :
                         src_res[s] ? result_q : reg_rd[src_idx[s]];
    assign reg_we[s]   = accept & act[s] & dst_reg[s];
  end

  tta_regfile #(.NREG(NREG), .DATA_W(DATA_W), .NSLOT(NSLOT)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .widx_i  (dst_idx),
    .wdat_i  (slot_dat),
    .rd_all_o(reg_rd)
  );

  // Highest-numbered slot takes the operand and trigger ports.
  always_comb begin
    trig_fire = 1'b0;
    fire_op   = OP_ADD;
    fire_val  = '0;
    opnd_we   = 1'b0;
    opnd_d    = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (accept && act[s] && dst_trig[s]) begin
        trig_fire = 1'b1;
        fire_op   = trig_op[s];
        fire_val  = slot_dat[s];
      end
      if (accept && act[s] && dst_opnd[s]) begin
        opnd_we = 1'b1;
        opnd_d  = slot_dat[s];
      end
    end
  end

  tta_alu_unit #(.DATA_W(DATA_W)) u_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_we_i (opnd_we),
    .opnd_d_i  (opnd_d),
    .fire_i    (trig_fire),
    .op_i      (fire_op),
    .val_i     (fire_val),
    .opnd_q_o  (opnd_q),
    .result_q_o(result_q)
  );

  assign any_bad = accept & (|bad);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (any_bad) err_q <= 1'b1;
  end

  assign dbg_data    = reg_rd[dbg_sel];
  assign operand_val = opnd_q;
  assign result_val  = result_q;
  assign err_flag    = err_q;
endmodule

// File: rtl/tta_core_chk.sv
module tta_core_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              instr_ready,
  input logic              trig_fire,
  input logic              opnd_we,
  input logic              any_bad,
  input logic              err_flag,
  input logic [DATA_W-1:0] result_val,
  input logic [DATA_W-1:0] operand_val
);
  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_fire |=> $stable(result_val));

  // R4
  fire_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |-> accept);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_bad |=> err_flag);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(operand_val) && $stable(result_val) && $stable(err_flag));

  // R3
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opnd_we |=> $stable(operand_val));
endmodule

bind tta_core tta_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .instr_ready(instr_ready),
  .trig_fire  (trig_fire),
  .opnd_we    (opnd_we),
  .any_bad    (any_bad),
  .err_flag   (err_flag),
  .result_val (result_val),
  .operand_val(operand_val)
);

// File: tb/tb_tta_core.sv
module tb_tta_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [21:0] instr_word = '0;
  logic [15:0] ext_in = '0;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] dbg_data, operand_val, result_val;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  tta_core dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .ext_in(ext_in), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .operand_val(operand_val), .result_val(result_val), .err_flag(err_flag)
  );

  localparam logic [4:0] C_OPND = 5'd8, C_ADD = 5'd9, C_SUB = 5'd10, C_AND = 5'd11,
                         C_OR = 5'd12, C_XOR = 5'd13, C_RES = 5'd14, C_EXT = 5'd15;

  function automatic logic [10:0] mv(logic [4:0] src, logic [4:0] dst);
    return {1'b1, src, dst};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int idx, output logic [15:0] v);
    dbg_sel = idx[2:0];
    #1 v = dbg_data;
  endtask

  task automatic chk_reg(string tag, int idx, logic [15:0] exp);
    logic [15:0] v;
    rd(idx, v);
    chk(tag, v, exp);
  endtask

  // Issue one instruction: slot1 in upper half, slot0 in lower half.
  task automatic issue(logic [10:0] s1, logic [10:0] s0, logic [15:0] ext = '0);
    @(negedge clk);
    instr_word  = {s1, s0};
    ext_in      = ext;
    instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) chk_reg("R1 reg clear", i, 16'h0);
    chk("R1 operand clear", operand_val, 16'h0);
    chk("R1 result clear", result_val, 16'h0);
    chk("R1 err clear", {15'd0, err_flag}, 16'h0);
    chk("R1 ready", {15'd0, instr_ready}, 16'h1);
  endtask

  task automatic t_load_swap();
    issue(11'd0, mv(C_EXT, 5'd1), 16'h1234);
    issue(11'd0, mv(C_EXT, 5'd2), 16'h00FF);
    chk_reg("R8 ext load r1", 1, 16'h1234);
    chk_reg("R8 ext load r2", 2, 16'h00FF);
    issue(mv(5'd2, 5'd1), mv(5'd1, 5'd2));
    chk_reg("R2 swap r1", 1, 16'h00FF);
    chk_reg("R2 swap r2", 2, 16'h1234);
  endtask

  task automatic t_operand_only();
    issue(11'd0, mv(5'd1, C_OPND));
    chk("R3 operand latched", operand_val, 16'h00FF);
    chk("R3 result unchanged", result_val, 16'h0000);
  endtask

  task automatic t_ops();
    issue(11'd0, mv(5'd2, C_ADD));
    chk("R4 add", result_val, 16'h1333);
    issue(11'd0, mv(C_RES, 5'd3));
    chk_reg("R4 result to r3", 3, 16'h1333);
    chk("R4 result held", result_val, 16'h1333);
    issue(11'd0, mv(5'd2, C_SUB));
    chk("R4 sub", result_val, 16'hEECB);
    issue(11'd0, mv(5'd2, C_AND));
    chk("R4 and", result_val, 16'h0034);
    issue(11'd0, mv(5'd2, C_OR));
    chk("R4 or", result_val, 16'h12FF);
    issue(11'd0, mv(5'd2, C_XOR));
    chk("R4 xor", result_val, 16'h12CB);
  endtask

  task automatic t_read_with_trigger();
    issue(mv(5'd1, C_ADD), mv(C_RES, 5'd4));
    chk_reg("R5 old result read", 4, 16'h12CB);
    chk("R5 new result", result_val, 16'h01FE);
  endtask

  task automatic t_operand_and_trigger();
    issue(mv(5'd2, C_AND), mv(5'd2, C_OPND));
    chk("R4 trigger uses old operand", result_val, 16'h0034);
    chk("R4 operand updated", operand_val, 16'h1234);
  endtask

  task automatic t_same_dest();
    issue(mv(5'd1, 5'd5), mv(C_EXT, 5'd5), 16'hAAAA);
    chk_reg("R6 higher slot wins", 5, 16'h00FF);
    issue(mv(C_EXT, 5'd5), mv(5'd1, 5'd5), 16'h5555);
    chk_reg("R6 higher slot wins swapped", 5, 16'h5555);
  endtask

  task automatic t_illegal();
    issue(mv(5'd2, 5'd7), mv(5'd8, 5'd6));
    chk_reg("R7 illegal src ignored", 6, 16'h0000);
    chk_reg("R7 legal slot kept", 7, 16'h1234);
    chk("R7 err set", {15'd0, err_flag}, 16'h1);
    issue(11'd0, mv(5'd1, C_RES));
    chk("R7 illegal dst result", result_val, 16'h0034);
    chk_reg("R7 illegal dst r1", 1, 16'h00FF);
    chk_reg("R7 illegal dst wrap r6", 6, 16'h0000);
    issue(11'd0, mv(5'd1, 5'd6));
    chk("R7 err sticky", {15'd0, err_flag}, 16'h1);
    chk_reg("R7 legal after err", 6, 16'h00FF);
  endtask

  task automatic t_idle();
    @(negedge clk);
    instr_word  = {11'd0, mv(C_EXT, 5'd0)};
    ext_in      = 16'hBEEF;
    instr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_reg("R8 valid low ignored", 0, 16'h0000);
    issue({1'b0, C_EXT, 5'd0}, {1'b0, 5'd1, C_ADD}, 16'hBEEF);
    chk_reg("R8 slot bit clear ignored", 0, 16'h0000);
    chk("R8 slot bit clear result", result_val, 16'h0034);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_load_swap();
    t_operand_only();
    t_ops();
    t_read_with_trigger();
    t_operand_and_trigger();
    t_same_dest();
    t_illegal();
    t_idle();
    do_reset();
    t_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule